// File: doc/BRIEF.md
# Multi-Bank SDRAM Command Spacing Checker

This block sits beside an SDRAM controller's command issue stage. It follows four banks and works out, every clock, which commands could be issued without breaking the minimum spacing rules between commands. It has one legality vector per command kind, with one bit per bank. It also has a single legality bit for each of mode-register load and auto refresh. All timers are parameters counted in clock cycles. Each timer loads when a command is accepted and counts down to zero. A command is legal only when every timer that constrains it has reached zero.

A command presented on the command port is either accepted or dropped. An accepted command updates the bank state and timers. A dropped command, which is illegal, changes no state. It raises a one-cycle violation pulse and latches a sticky error. The block also flags a row that has stayed open longer than the maximum row-active time. The controller can use the legality vectors to gate its own issue logic, or it can feed its command stream through the block purely as a protocol monitor.

Top module: `dram_cmd_timing_check`

## Requirements
- R1: After reset all banks are closed and no violation or error is shown. ACTIVE, PRECHARGE, LOAD MODE and REFRESH are legal for every bank. READ, WRITE and both auto-precharge forms are illegal.
- R2: `cmd_op` codes are 0 idle, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 READ with auto-precharge, 6 WRITE with auto-precharge, 7 LOAD MODE and 8 REFRESH. Codes 9 to 15 are ignored. `cmd_bank` selects the bank. `bank_open` shows the open state of each bank from the cycle after the accepted command.
- R3: READ or WRITE to a bank is legal no earlier than T_RCD cycles after the ACTIVE to that bank.
- R4: PRECHARGE of an open bank needs T_RAS cycles since its ACTIVE. It also needs 1 + BURST/2 + T_WR cycles since the last WRITE to that bank.
- R5: ACTIVE to a bank needs T_RC cycles since the previous ACTIVE to it. It also needs T_RP cycles since it was precharged.
- R6: Any ACTIVE needs T_RRD cycles since the last ACTIVE to any bank.
- R7: READ in either form needs 1 + BURST/2 + T_WTR cycles since the last WRITE in either form to any bank.
- R8: READ with auto-precharge is legal only if at most BURST/2 cycles of row-active time remain. WRITE with auto-precharge is legal only if at most 1 + BURST/2 + T_WR cycles remain. Either form closes the bank. The next ACTIVE to that bank then waits for that delay plus T_RP.
- R9: LOAD MODE needs every bank closed and precharged. After it, every command waits T_MRD cycles.
- R10: REFRESH needs every bank closed, precharged and past T_RC. After it, every command waits T_RFC cycles.
- R11: READ, WRITE or an auto-precharge command to a closed bank is illegal, and so is ACTIVE to an open bank. PRECHARGE of a closed bank is legal and has no effect.
- R12: An issued illegal command changes no state. It gives `violation` high in the next cycle, and only then.
- R13: `row_overdue` of a bank is high while that bank has been open for more than T_RAS_MAX cycles.
- R14: `err_sticky` goes high the cycle after a violation or any overdue row, and it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command code (see R2) |
| cmd_bank | input | 2 | Target bank |
| legal_act | output | 4 | ACTIVE legal, per bank |
| legal_rd | output | 4 | READ legal, per bank |
| legal_wr | output | 4 | WRITE legal, per bank |
| legal_pre | output | 4 | PRECHARGE legal, per bank |
| legal_rda | output | 4 | READ with auto-precharge legal, per bank |
| legal_wra | output | 4 | WRITE with auto-precharge legal, per bank |
| legal_lmr | output | 1 | LOAD MODE legal |
| legal_ref | output | 1 | REFRESH legal |
| bank_open | output | 4 | Row open, per bank |
| row_overdue | output | 4 | Row open beyond T_RAS_MAX, per bank |
| violation | output | 1 | Illegal command seen in previous cycle |
| err_sticky | output | 1 | Latched error |

## Verification
The legality vectors come straight from registered timers. A rule of N cycles that starts from a command accepted at edge t therefore first shows as legal in the cycle that begins N edges after t. `bank_open`, `violation` and `err_sticky` change in the cycle right after the command edge. The bench holds a timestamp model for each bank. It gives every command the cycle index in which it was driven. It compares every output once per cycle at the falling edge, after the model has been brought up to date with all earlier commands. The outputs are therefore checked in the exact cycle each rule expires, and never one cycle early or late.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0,
    OP_ACT = 4'd1,
    OP_RD  = 4'd2,
    OP_WR  = 4'd3,
    OP_PRE = 4'd4,
    OP_RDA = 4'd5,
    OP_WRA = 4'd6,
    OP_LMR = 4'd7,
    OP_REF = 4'd8
  } dct_op_e;

  // cycles from a read command to the internal precharge point
  function automatic int rd_to_ipre(input int burst);
    return burst / 2;
  endfunction

  // cycles from a write command until precharge may start (latency 1, data, recovery)
  function automatic int wr_to_ipre(input int burst, input int twr);
    return 1 + burst / 2 + twr;
  endfunction

  // cycles from a write command until a read may be issued
  function automatic int wr_to_rd(input int burst, input int twtr);
    return 1 + burst / 2 + twtr;
  endfunction

  // value a countdown loads so that the rule expires N edges after the command
  function automatic int load_of(input int n);
    return (n > 0) ? n - 1 : 0;
  endfunction

endpackage

// File: rtl/dct_downcnt.sv
module dct_downcnt #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/dct_bank.sv
module dct_bank
  import dct_pkg::*;
#(
  parameter int CW        = 6,
  parameter int AW        = 6,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 8,
  parameter int T_RAS_MAX = 40,
  parameter int T_RC      = 11,
  parameter int T_RP      = 3,
  parameter int RD2PRE    = 2,
  parameter int WR2PRE    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_act,
  input  logic          do_wr,
  input  logic          do_pre,
  input  logic          do_rda,
  input  logic          do_wra,
  output logic          is_open,
  output logic          rcd_done,
  output logic          rc_done,
  output logic          rp_done,
  output logic          wr_done,
  output logic [CW-1:0] ras_left,
  output logic          overdue
);
  logic [CW-1:0] rcd_cnt, rc_cnt, rp_cnt, wr_cnt;
  logic [CW-1:0] rp_val;
  logic [AW-1:0] age;
  logic          closing;

  assign closing = do_pre | do_rda | do_wra;

  always_comb begin
    if (do_pre)      rp_val = CW'(load_of(T_RP));
    else if (do_rda) rp_val = CW'(load_of(RD2PRE + T_RP));
    else             rp_val = CW'(load_of(WR2PRE + T_RP));
  end

  dct_downcnt #(.CW(CW)) u_rcd (.clk(clk), .rst_n(rst_n), .load(do_act),
    .load_val(CW'(load_of(T_RCD))), .cnt(rcd_cnt));
  dct_downcnt #(.CW(CW)) u_ras (.clk(clk), .rst_n(rst_n), .load(do_act),
    .load_val(CW'(load_of(T_RAS))), .cnt(ras_left));
  dct_downcnt #(.CW(CW)) u_rc (.clk(clk), .rst_n(rst_n), .load(do_act),
    .load_val(CW'(load_of(T_RC))), .cnt(rc_cnt));
  dct_downcnt #(.CW(CW)) u_rp (.clk(clk), .rst_n(rst_n), .load(closing),
    .load_val(rp_val), .cnt(rp_cnt));
  dct_downcnt #(.CW(CW)) u_wr (.clk(clk), .rst_n(rst_n), .load(do_wr),
    .load_val(CW'(load_of(WR2PRE))), .cnt(wr_cnt));

  assign rcd_done = (rcd_cnt == '0);
  assign rc_done  = (rc_cnt == '0);
  assign rp_done  = (rp_cnt == '0);
  assign wr_done  = (wr_cnt == '0);

  // open state and age of the row since activation (saturates past the limit)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      age     <= '0;
    end else if (do_act) begin
      is_open <= 1'b1;
      age     <= AW'(1);
    end else if (closing) begin
      is_open <= 1'b0;
      age     <= '0;
    end else if (is_open && age <= AW'(T_RAS_MAX)) begin
      age     <= age + 1'b1;
    end
  end

  assign overdue = is_open && (age > AW'(T_RAS_MAX));
endmodule

// File: rtl/dct_shared.sv
module dct_shared
  import dct_pkg::*;
#(
  parameter int CW    = 6,
  parameter int T_RRD = 2,
  parameter int WR2RD = 4,
  parameter int T_MRD = 2,
  parameter int T_RFC = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_act,
  input  logic any_wr,
  input  logic any_lmr,
  input  logic any_ref,
  output logic rrd_done,
  output logic wtr_done,
  output logic mrd_done,
  output logic rfc_done
);
  logic [CW-1:0] rrd_cnt, wtr_cnt, mrd_cnt, rfc_cnt;

  dct_downcnt #(.CW(CW)) u_rrd (.clk(clk), .rst_n(rst_n), .load(any_act),
    .load_val(CW'(load_of(T_RRD))), .cnt(rrd_cnt));
  dct_downcnt #(.CW(CW)) u_wtr (.clk(clk), .rst_n(rst_n), .load(any_wr),
    .load_val(CW'(load_of(WR2RD))), .cnt(wtr_cnt));
  dct_downcnt #(.CW(CW)) u_mrd (.clk(clk), .rst_n(rst_n), .load(any_lmr),
    .load_val(CW'(load_of(T_MRD))), .cnt(mrd_cnt));
  dct_downcnt #(.CW(CW)) u_rfc (.clk(clk), .rst_n(rst_n), .load(any_ref),
    .load_val(CW'(load_of(T_RFC))), .cnt(rfc_cnt));

  assign rrd_done = (rrd_cnt == '0);
  assign wtr_done = (wtr_cnt == '0);
  assign mrd_done = (mrd_cnt == '0);
  assign rfc_done = (rfc_cnt == '0);
endmodule

// File: rtl/dram_cmd_timing_check.sv
module dram_cmd_timing_check
  import dct_pkg::*;
#(
  parameter int NB        = 4,
  parameter int BURST     = 4,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 8,
  parameter int T_RAS_MAX = 40,
  parameter int T_RC      = 11,
  parameter int T_RP      = 3,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 3,
  parameter int T_WTR     = 1,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic [3:0]              cmd_op,
  input  logic [$clog2(NB)-1:0]   cmd_bank,
  output logic [NB-1:0]           legal_act,
  output logic [NB-1:0]           legal_rd,
  output logic [NB-1:0]           legal_wr,
  output logic [NB-1:0]           legal_pre,
  output logic [NB-1:0]           legal_rda,
  output logic [NB-1:0]           legal_wra,
  output logic                    legal_lmr,
  output logic                    legal_ref,
  output logic [NB-1:0]           bank_open,
  output logic [NB-1:0]           row_overdue,
  output logic                    violation,
  output logic                    err_sticky
);
  localparam int RD2PRE = rd_to_ipre(BURST);
  localparam int WR2PRE = wr_to_ipre(BURST, T_WR);
  localparam int WR2RD  = wr_to_rd(BURST, T_WTR);
  localparam int CW     = $clog2(T_RFC + T_RC + T_RAS + WR2PRE + T_RP + T_MRD + WR2RD + 2);
  localparam int AW     = $clog2(T_RAS_MAX + 2);

  // named internal events
  logic          issued, cmd_legal, accepted;
  logic          acc_act, acc_rd, acc_wr, acc_pre, acc_rda, acc_wra, acc_lmr, acc_ref;
  logic [NB-1:0] rcd_done, rc_done, rp_done, wr_done;
  logic [CW-1:0] ras_left [NB];
  logic          rrd_done, wtr_done, mrd_done, rfc_done, gate;

  assign issued = cmd_valid && (cmd_op >= OP_ACT) && (cmd_op <= OP_REF);

  always_comb begin
    unique case (cmd_op)
      OP_ACT:  cmd_legal = legal_act[cmd_bank];
      OP_RD:   cmd_legal = legal_rd[cmd_bank];
      OP_WR:   cmd_legal = legal_wr[cmd_bank];
      OP_PRE:  cmd_legal = legal_pre[cmd_bank];
      OP_RDA:  cmd_legal = legal_rda[cmd_bank];
      OP_WRA:  cmd_legal = legal_wra[cmd_bank];
      OP_LMR:  cmd_legal = legal_lmr;
      OP_REF:  cmd_legal = legal_ref;
      default: cmd_legal = 1'b1;
    endcase
  end

  assign accepted = issued && cmd_legal;
  assign acc_act  = accepted && (cmd_op == OP_ACT);
  assign acc_rd   = accepted && (cmd_op == OP_RD);
  assign acc_wr   = accepted && (cmd_op == OP_WR);
  assign acc_pre  = accepted && (cmd_op == OP_PRE);
  assign acc_rda  = accepted && (cmd_op == OP_RDA);
  assign acc_wra  = accepted && (cmd_op == OP_WRA);
  assign acc_lmr  = accepted && (cmd_op == OP_LMR);
  assign acc_ref  = accepted && (cmd_op == OP_REF);

  dct_shared #(.CW(CW), .T_RRD(T_RRD), .WR2RD(WR2RD), .T_MRD(T_MRD), .T_RFC(T_RFC)) u_shared (
    .clk(clk), .rst_n(rst_n),
    .any_act(acc_act), .any_wr(acc_wr | acc_wra), .any_lmr(acc_lmr), .any_ref(acc_ref),
    .rrd_done(rrd_done), .wtr_done(wtr_done), .mrd_done(mrd_done), .rfc_done(rfc_done));

  assign gate = mrd_done && rfc_done;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit;
    assign hit = (cmd_bank == b[$clog2(NB)-1:0]);

    dct_bank #(.CW(CW), .AW(AW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RAS_MAX(T_RAS_MAX),
               .T_RC(T_RC), .T_RP(T_RP), .RD2PRE(RD2PRE), .WR2PRE(WR2PRE)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .do_act(acc_act && hit),
      .do_wr(acc_wr && hit),
      .do_pre(acc_pre && hit && bank_open[b]),
      .do_rda(acc_rda && hit),
      .do_wra(acc_wra && hit),
      .is_open(bank_open[b]),
      .rcd_done(rcd_done[b]), .rc_done(rc_done[b]), .rp_done(rp_done[b]),
      .wr_done(wr_done[b]), .ras_left(ras_left[b]), .overdue(row_overdue[b]));

    assign legal_act[b] = !bank_open[b] && rc_done[b] && rp_done[b] && rrd_done && gate;
    assign legal_rd[b]  = bank_open[b] && rcd_done[b] && wtr_done && gate;
    assign legal_wr[b]  = bank_open[b] && rcd_done[b] && gate;
    assign legal_rda[b] = legal_rd[b] && (ras_left[b] <= CW'(RD2PRE));
    assign legal_wra[b] = legal_wr[b] && (ras_left[b] <= CW'(WR2PRE));
    assign legal_pre[b] = gate && (!bank_open[b] || (ras_left[b] == '0 && wr_done[b]));
  end

  assign legal_lmr = !(|bank_open) && (&rp_done) && gate;
  assign legal_ref = !(|bank_open) && (&rp_done) && (&rc_done) && gate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      violation  <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      violation  <= issued && !cmd_legal;
      err_sticky <= err_sticky || (issued && !cmd_legal) || (|row_overdue);
    end
  end

  // acc_rd needs no state; it is named for visibility
  logic unused_rd;
  assign unused_rd = acc_rd;
endmodule

// File: rtl/dct_chk.sv
module dct_chk #(
  parameter int NB    = 4,
  parameter int T_RCD = 3,
  parameter int T_RRD = 2,
  parameter int T_RFC = 15
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  issued,
  input logic                  cmd_legal,
  input logic                  acc_act,
  input logic                  acc_pre,
  input logic                  acc_ref,
  input logic [$clog2(NB)-1:0] cmd_bank,
  input logic [NB-1:0]         bank_open,
  input logic [NB-1:0]         row_overdue,
  input logic [NB-1:0]         legal_act,
  input logic [NB-1:0]         legal_rd,
  input logic [NB-1:0]         legal_wr,
  input logic [NB-1:0]         legal_pre,
  input logic [NB-1:0]         legal_rda,
  input logic [NB-1:0]         legal_wra,
  input logic                  legal_lmr,
  input logic                  legal_ref,
  input logic                  violation,
  input logic                  err_sticky
);
  // R12
  illegal_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issued && !cmd_legal) |=> violation);
  // R12
  legal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(issued && !cmd_legal) |=> !violation);
  // R14
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
  // R13
  overdue_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|row_overdue) |=> err_sticky);
  // R2
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_act |=> bank_open[$past(cmd_bank)]);
  // R11
  pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_pre && bank_open[cmd_bank]) |=> !bank_open[$past(cmd_bank)]);
  // R3
  rcd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_act && T_RCD > 1) |=> !legal_rd[$past(cmd_bank)] && !legal_wr[$past(cmd_bank)]);
  // R6
  rrd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_act && T_RRD > 1) |=> (legal_act == '0));
  // R10
  rfc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ref && T_RFC > 1) |=> ((legal_act | legal_rd | legal_wr | legal_pre | legal_rda | legal_wra) == '0)
                               && !legal_lmr && !legal_ref);
endmodule

bind dram_cmd_timing_check dct_chk #(.NB(NB), .T_RCD(T_RCD), .T_RRD(T_RRD), .T_RFC(T_RFC)) u_chk (
  .clk(clk), .rst_n(rst_n), .issued(issued), .cmd_legal(cmd_legal),
  .acc_act(acc_act), .acc_pre(acc_pre), .acc_ref(acc_ref), .cmd_bank(cmd_bank),
  .bank_open(bank_open), .row_overdue(row_overdue),
  .legal_act(legal_act), .legal_rd(legal_rd), .legal_wr(legal_wr), .legal_pre(legal_pre),
  .legal_rda(legal_rda), .legal_wra(legal_wra), .legal_lmr(legal_lmr), .legal_ref(legal_ref),
  .violation(violation), .err_sticky(err_sticky));

// File: tb/dram_cmd_timing_check_test.sv
module dram_cmd_timing_check_test;
  localparam int BURST = 4, T_RCD = 3, T_RAS = 8, T_RAS_MAX = 40, T_RC = 11, T_RP = 3;
  localparam int T_RRD = 2, T_WR = 3, T_WTR = 1, T_MRD = 2, T_RFC = 15;
  // bench restatement of derived spacings
  localparam int RDP  = BURST / 2;
  localparam int WRP  = T_WR + BURST / 2 + 1;
  localparam int W2R  = T_WTR + 1 + BURST / 2;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [3:0] cmd_op = 4'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic [3:0] legal_act, legal_rd, legal_wr, legal_pre, legal_rda, legal_wra, bank_open, row_overdue;
  logic legal_lmr, legal_ref, violation, err_sticky;

  always #2.5 clk = ~clk;

  dram_cmd_timing_check #(.NB(4), .BURST(BURST), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RAS_MAX(T_RAS_MAX),
    .T_RC(T_RC), .T_RP(T_RP), .T_RRD(T_RRD), .T_WR(T_WR), .T_WTR(T_WTR), .T_MRD(T_MRD), .T_RFC(T_RFC)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .legal_act(legal_act), .legal_rd(legal_rd), .legal_wr(legal_wr), .legal_pre(legal_pre),
    .legal_rda(legal_rda), .legal_wra(legal_wra), .legal_lmr(legal_lmr), .legal_ref(legal_ref),
    .bank_open(bank_open), .row_overdue(row_overdue), .violation(violation), .err_sticky(err_sticky));

  int checks = 0, failures = 0, n = 0;
  bit finished = 0;
  // timestamp model
  int act_t [4], rc_ok [4], rcd_ok [4], rp_ok [4], wrp_ok [4];
  bit m_open [4];
  int rrd_ok, wtr_ok, mrd_ok, rfc_ok;
  bit viol_exp, err_exp;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", tag, n, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 4; b++) begin
      act_t[b] = 0; rc_ok[b] = 0; rcd_ok[b] = 0; rp_ok[b] = 0; wrp_ok[b] = 0; m_open[b] = 0;
    end
    rrd_ok = 0; wtr_ok = 0; mrd_ok = 0; rfc_ok = 0; viol_exp = 0; err_exp = 0;
  endtask

  function automatic bit idle_all(input bit need_rc);
    bit r = 1;
    for (int b = 0; b < 4; b++)
      if (m_open[b] || n < rp_ok[b] || (need_rc && n < rc_ok[b])) r = 0;
    return r;
  endfunction

  function automatic bit mlegal(input int op, input int b);
    bit g = (n >= mrd_ok) && (n >= rfc_ok);
    bit rd = m_open[b] && n >= rcd_ok[b] && n >= wtr_ok && g;
    bit wr = m_open[b] && n >= rcd_ok[b] && g;
    case (op)
      1: return !m_open[b] && n >= rc_ok[b] && n >= rp_ok[b] && n >= rrd_ok && g;
      2: return rd;
      3: return wr;
      4: return g && (!m_open[b] || (n >= act_t[b] + T_RAS && n >= wrp_ok[b]));
      5: return rd && n >= act_t[b] + T_RAS - RDP;
      6: return wr && n >= act_t[b] + T_RAS - WRP;
      7: return g && idle_all(0);
      8: return g && idle_all(1);
      default: return 1;
    endcase
  endfunction

  function automatic logic [3:0] mvec(input int op);
    logic [3:0] v;
    for (int b = 0; b < 4; b++) v[b] = mlegal(op, b);
    return v;
  endfunction

  function automatic logic [3:0] movd();
    logic [3:0] v;
    for (int b = 0; b < 4; b++) v[b] = m_open[b] && (n - act_t[b] > T_RAS_MAX);
    return v;
  endfunction

  task automatic apply(input int op, input int b);
    case (op)
      1: begin m_open[b] = 1; act_t[b] = n; rc_ok[b] = n + T_RC; rcd_ok[b] = n + T_RCD; rrd_ok = n + T_RRD; end
      3: begin wrp_ok[b] = n + WRP; wtr_ok = n + W2R; end
      4: if (m_open[b]) begin m_open[b] = 0; rp_ok[b] = n + T_RP; end
      5: begin m_open[b] = 0; rp_ok[b] = n + RDP + T_RP; end
      6: begin m_open[b] = 0; rp_ok[b] = n + WRP + T_RP; wtr_ok = n + W2R; end
      7: mrd_ok = n + T_MRD;
      8: rfc_ok = n + T_RFC;
      default: ;
    endcase
  endtask

  task automatic compare();
    logic [3:0] m_openv;
    for (int b = 0; b < 4; b++) m_openv[b] = m_open[b];
    chk(legal_act == mvec(1), "R5 R6 R11 legal_act", legal_act, mvec(1));
    chk(legal_rd  == mvec(2), "R3 R7 legal_rd", legal_rd, mvec(2));
    chk(legal_wr  == mvec(3), "R3 legal_wr", legal_wr, mvec(3));
    chk(legal_pre == mvec(4), "R4 R11 legal_pre", legal_pre, mvec(4));
    chk(legal_rda == mvec(5), "R8 legal_rda", legal_rda, mvec(5));
    chk(legal_wra == mvec(6), "R8 legal_wra", legal_wra, mvec(6));
    chk(legal_lmr == mlegal(7, 0), "R9 legal_lmr", legal_lmr, mlegal(7, 0));
    chk(legal_ref == mlegal(8, 0), "R10 legal_ref", legal_ref, mlegal(8, 0));
    chk(bank_open == m_openv, "R2 bank_open", bank_open, m_openv);
    chk(row_overdue == movd(), "R13 row_overdue", row_overdue, movd());
    chk(violation == viol_exp, "R12 violation", violation, viol_exp);
    chk(err_sticky == err_exp, "R14 err_sticky", err_sticky, err_exp);
  endtask

  task automatic step(input int op, input int b);
    bit ill, ov;
    @(negedge clk);
    n++;
    compare();
    ov  = |movd();
    ill = (op >= 1 && op <= 8) && !mlegal(op, b);
    if (!ill) apply(op, b);
    err_exp  = err_exp | ill | ov;
    viol_exp = ill;
    cmd_valid = (op != 0);
    cmd_op    = 4'(op);
    cmd_bank  = 2'(b);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cmd_valid = 0; cmd_op = 0;
    repeat (3) @(negedge clk);
    n += 4;
    model_reset();
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(bank_open == 4'h0 && !err_sticky && !violation, "R1 reset idle", {bank_open, err_sticky, violation}, 0);
    chk(legal_act == 4'hF && legal_pre == 4'hF && legal_lmr && legal_ref, "R1 reset legal",
        {legal_act, legal_pre, legal_lmr, legal_ref}, 10'h3FF);
    chk((legal_rd | legal_wr | legal_rda | legal_wra) == 4'h0, "R1 reset no access",
        legal_rd | legal_wr | legal_rda | legal_wra, 0);
    // legal-only run: R3 R7 R4 exact boundaries
    step(1, 0); idle(T_RCD - 1); step(3, 0); idle(W2R - 1); step(2, 0);
    step(4, 2);                        // R11 precharge of closed bank, no effect
    step(9, 1);                        // R2 reserved code ignored
    idle(WRP); step(4, 0); idle(T_RP + T_RC); step(7, 0); idle(T_MRD); step(8, 0); idle(T_RFC);
    chk(err_sticky == 0, "R14 no error on legal traffic", err_sticky, 0);
    // deliberate violations
    step(1, 1); step(1, 2);            // R6 too close
    step(2, 1); step(5, 1); idle(2); step(5, 1);   // R3 R8 early, then legal
    step(2, 3);                        // R11 read closed bank
    step(1, 1); idle(T_RP); step(1, 1); // R5 R11
    step(6, 1); step(7, 0); step(8, 0); // R8 R9 R10
    // R13 overdue row
    idle(T_RC); step(1, 2); idle(T_RAS_MAX + 4); step(4, 2); idle(3);
    // R14 cleared only by reset
    do_reset(); idle(2);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 9);
      int b  = $urandom_range(0, 3);
      if (op >= 1 && op <= 8 && !mlegal(op, b) && $urandom_range(0, 5) != 0) op = 0;
      step(op, b);
      if (i == 2000) do_reset();
    end
    idle(2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule